// File: doc/BRIEF.md
# Chain DMA Sequencer with Inline Tags

This block is the control state machine of one DMA channel. Software loads a count, a destination address and a scratch-side source pointer, then pulses start. In normal mode the channel moves the loaded number of quadwords once and completes. In chain mode the payload is described by tags that sit in the source stream itself. The sequencer reads a tag at the scratch pointer and steps the pointer past the 16-byte tag. It loads the count and destination from the tag, hands one burst to an external mover, and then fetches the next tag or finishes.

The tag's ID field decides whether the chain goes on. An interrupt-enable input combined with the tag's IRQ bit also stops the chain once the current payload has moved. The stall-control ID records where its payload ends in a stall-address register. On completion the busy (start) flag drops and a one-cycle completion interrupt is raised. The tag port carries the low 64 bits of each 128-bit tag, which hold every field the sequencer decodes.

Top module: `chain_dma_seq`

## Requirements
- R1: After reset busy_o, done_irq_o, err_o, tag_req_o and mv_req_o are 0, and stall_addr_o and qwc_o read 0.
- R2: In normal mode (chain_i=0) the loaded count is moved as one burst from the source pointer to the destination. Both pointers then advance by count*16 and the channel completes without reading any tag.
- R3: In chain mode with a nonzero loaded count, that block is moved as one burst and the channel completes without reading a tag.
- R4: In chain mode with a zero loaded count, the tag is read at the scratch pointer, and the pointer advances by 16 before the payload burst, whose source is therefore tag address + 16.
- R5: Tag fields: count in bits [15:0], destination in bits [63:32], ID in bits [30:28], IRQ flag in bit 31.
- R6: ID 1 (count) continues the chain with the next tag after the payload, and ID 7 (end) completes the channel after the payload.
- R7: ID 0 (count with stall) continues the chain. When stall_sel_i is 1 it writes stall_addr_o = destination + count*16. When stall_sel_i is 0, stall_addr_o keeps its value.
- R8: With irq_en_i=1, a tag whose IRQ bit is 1 ends the chain after its payload. With irq_en_i=0 the IRQ bit has no effect.
- R9: A tag with a zero count issues no burst, and the chain then continues or ends as its ID says.
- R10: Any ID other than 0, 1 or 7 moves no payload, sets err_o, and completes the channel. err_o clears at the next start.
- R11: On completion busy_o falls and done_irq_o is 1 for exactly one cycle, in the same cycle.
- R12: mv_req_o holds with stable source until mv_done_i, and qwc_o reads 0 in the cycle after the burst is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, taken when idle |
| chain_i | input | 1 | 1 selects chain mode, 0 normal mode |
| irq_en_i | input | 1 | Channel interrupt enable (honours tag IRQ bit) |
| stall_sel_i | input | 1 | Stall control selects this channel |
| qwc_init_i | input | CNT_W | Initial quadword count |
| madr_init_i | input | ADDR_W | Initial destination address |
| sadr_init_i | input | ADDR_W | Initial scratch (source) pointer |
| tag_req_o | output | 1 | Tag read request |
| tag_addr_o | output | ADDR_W | Tag read address |
| tag_vld_i | input | 1 | Tag data valid |
| tag_data_i | input | TAG_W | Low half of the tag |
| mv_req_o | output | 1 | Burst request to the mover |
| mv_src_o | output | ADDR_W | Burst source address |
| mv_dst_o | output | ADDR_W | Burst destination address |
| mv_qwc_o | output | CNT_W | Burst length in quadwords |
| mv_done_i | input | 1 | Mover acknowledges the burst |
| busy_o | output | 1 | Channel start flag |
| done_irq_o | output | 1 | Completion interrupt pulse |
| err_o | output | 1 | Unsupported tag ID seen |
| stall_addr_o | output | ADDR_W | Stall address register |
| qwc_o | output | CNT_W | Current count register |
| madr_o | output | ADDR_W | Current destination register |
| sadr_o | output | ADDR_W | Current scratch pointer |

## Verification
A tag returned with tag_vld_i is latched at that edge and decoded at the next one, so the burst request (or the next tag request) becomes visible two edges after the valid cycle. An acknowledged burst clears qwc_o by the following edge, and done_irq_o appears two edges after the final acknowledge together with busy_o falling. The bench models the tag port and the mover at the falling edge and compares each new burst against a queue of expected bursts the moment its request first appears. It checks qwc_o one falling edge after each acknowledge and checks the final pointers, flags and stall address on the falling edge where done_irq_o is seen.

// File: rtl/chain_dma_pkg.sv
package chain_dma_pkg;
  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_DECODE, S_XFER, S_DONE} seq_state_e;
  typedef enum logic [1:0] {ACT_CONT, ACT_STOP, ACT_BAD} tag_act_e;

  localparam logic [2:0] ID_CNTS = 3'd0;
  localparam logic [2:0] ID_CNT  = 3'd1;
  localparam logic [2:0] ID_END  = 3'd7;

  localparam int TAG_ID_LSB   = 28;
  localparam int TAG_IRQ_BIT  = 31;
  localparam int TAG_ADDR_LSB = 32;
  localparam int QW_SHIFT     = 4;
endpackage

// File: rtl/chain_dma_tag_dec.sv
module chain_dma_tag_dec
  import chain_dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int TAG_W  = 64
) (
  input  logic [TAG_W-1:0]  tag_i,
  input  logic              irq_en_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [ADDR_W-1:0] dst_o,
  output tag_act_e          act_o,
  output logic              is_stall_o
);
  logic [2:0] id;
  logic       irq;
  logic       unused_rsvd;

  assign id          = tag_i[TAG_ID_LSB +: 3];
  assign irq         = tag_i[TAG_IRQ_BIT];
  assign cnt_o       = tag_i[CNT_W-1:0];
  assign dst_o       = tag_i[TAG_ADDR_LSB +: ADDR_W];
  assign unused_rsvd = ^tag_i[TAG_ID_LSB-1:CNT_W];

  always_comb begin
    is_stall_o = 1'b0;
    case (id)
      ID_CNTS: begin act_o = ACT_CONT; is_stall_o = 1'b1; end
      ID_CNT:  act_o = ACT_CONT;
      ID_END:  act_o = ACT_STOP;
      default: act_o = ACT_BAD;
    endcase
    if (act_o == ACT_CONT && irq_en_i && irq) act_o = ACT_STOP;
  end
endmodule

// File: rtl/chain_dma_stall_reg.sv
module chain_dma_stall_reg
  import chain_dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] dst_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] span;
  assign span = ADDR_W'(cnt_i) << QW_SHIFT;

  always_ff @(posedge clk) begin
    if (rst)       addr_o <= '0;
    else if (we_i) addr_o <= dst_i + span;
  end
endmodule

// File: rtl/chain_dma_seq.sv
module chain_dma_seq
  import chain_dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int TAG_W  = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              chain_i,
  input  logic              irq_en_i,
  input  logic              stall_sel_i,
  input  logic [CNT_W-1:0]  qwc_init_i,
  input  logic [ADDR_W-1:0] madr_init_i,
  input  logic [ADDR_W-1:0] sadr_init_i,
  output logic              tag_req_o,
  output logic [ADDR_W-1:0] tag_addr_o,
  input  logic              tag_vld_i,
  input  logic [TAG_W-1:0]  tag_data_i,
  output logic              mv_req_o,
  output logic [ADDR_W-1:0] mv_src_o,
  output logic [ADDR_W-1:0] mv_dst_o,
  output logic [CNT_W-1:0]  mv_qwc_o,
  input  logic              mv_done_i,
  output logic              busy_o,
  output logic              done_irq_o,
  output logic              err_o,
  output logic [ADDR_W-1:0] stall_addr_o,
  output logic [CNT_W-1:0]  qwc_o,
  output logic [ADDR_W-1:0] madr_o,
  output logic [ADDR_W-1:0] sadr_o
);
  localparam logic [ADDR_W-1:0] TAG_BYTES = ADDR_W'(1) << QW_SHIFT;

  seq_state_e        state_q;
  logic [CNT_W-1:0]  qwc_q;
  logic [ADDR_W-1:0] madr_q, sadr_q, span;
  logic [TAG_W-1:0]  tag_q;
  logic              last_q, busy_q, irq_q, err_q;

  logic [CNT_W-1:0]  dec_cnt;
  logic [ADDR_W-1:0] dec_dst;
  tag_act_e          dec_act;
  logic              dec_stall, stall_we;

  chain_dma_tag_dec #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .TAG_W(TAG_W)) u_dec (
    .tag_i(tag_q), .irq_en_i(irq_en_i), .cnt_o(dec_cnt), .dst_o(dec_dst),
    .act_o(dec_act), .is_stall_o(dec_stall)
  );

  assign stall_we = (state_q == S_DECODE) && dec_stall && stall_sel_i && (dec_act != ACT_BAD);

  chain_dma_stall_reg #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_stall (
    .clk(clk), .rst(rst), .we_i(stall_we), .dst_i(dec_dst), .cnt_i(dec_cnt),
    .addr_o(stall_addr_o)
  );

  assign span = ADDR_W'(qwc_q) << QW_SHIFT;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_IDLE;
      qwc_q   <= '0;
      madr_q  <= '0;
      sadr_q  <= '0;
      tag_q   <= '0;
      last_q  <= 1'b0;
      busy_q  <= 1'b0;
      irq_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      case (state_q)
        S_IDLE: begin
          irq_q <= 1'b0;
          if (start_i) begin
            busy_q <= 1'b1;
            err_q  <= 1'b0;
            qwc_q  <= qwc_init_i;
            madr_q <= madr_init_i;
            sadr_q <= sadr_init_i;
            if (!chain_i || qwc_init_i != '0) begin
              last_q  <= 1'b1;
              state_q <= (qwc_init_i != '0) ? S_XFER : S_DONE;
            end else begin
              last_q  <= 1'b0;
              state_q <= S_FETCH;
            end
          end
        end
        S_FETCH: begin
          if (tag_vld_i) begin
            tag_q   <= tag_data_i;
            sadr_q  <= sadr_q + TAG_BYTES;
            state_q <= S_DECODE;
          end
        end
        S_DECODE: begin
          madr_q <= dec_dst;
          last_q <= (dec_act != ACT_CONT);
          if (dec_act == ACT_BAD) begin
            err_q   <= 1'b1;
            qwc_q   <= '0;
            state_q <= S_DONE;
          end else begin
            qwc_q <= dec_cnt;
            if (dec_cnt != '0)            state_q <= S_XFER;
            else if (dec_act == ACT_STOP) state_q <= S_DONE;
            else                          state_q <= S_FETCH;
          end
        end
        S_XFER: begin
          if (mv_done_i) begin
            sadr_q  <= sadr_q + span;
            madr_q  <= madr_q + span;
            qwc_q   <= '0;
            state_q <= last_q ? S_DONE : S_FETCH;
          end
        end
        S_DONE: begin
          busy_q  <= 1'b0;
          irq_q   <= 1'b1;
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign tag_req_o  = (state_q == S_FETCH);
  assign tag_addr_o = sadr_q;
  assign mv_req_o   = (state_q == S_XFER);
  assign mv_src_o   = sadr_q;
  assign mv_dst_o   = madr_q;
  assign mv_qwc_o   = qwc_q;
  assign busy_o     = busy_q;
  assign done_irq_o = irq_q;
  assign err_o      = err_q;
  assign qwc_o      = qwc_q;
  assign madr_o     = madr_q;
  assign sadr_o     = sadr_q;
endmodule

// File: rtl/chain_dma_seq_chk.sv
module chain_dma_seq_chk #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              busy_o,
  input logic              done_irq_o,
  input logic              tag_req_o,
  input logic              mv_req_o,
  input logic              mv_done_i,
  input logic [ADDR_W-1:0] mv_src_o,
  input logic [CNT_W-1:0]  mv_qwc_o,
  input logic [CNT_W-1:0]  qwc_o
);
  a_r11_irq_not_busy: assert property (@(posedge clk) disable iff (rst)
    done_irq_o |-> !busy_o);
  a_r11_irq_one_cycle: assert property (@(posedge clk) disable iff (rst)
    done_irq_o |=> !done_irq_o);
  a_r12_req_held: assert property (@(posedge clk) disable iff (rst)
    (mv_req_o && !mv_done_i) |=> mv_req_o);
  a_r12_src_stable: assert property (@(posedge clk) disable iff (rst)
    (mv_req_o && !mv_done_i) |=> $stable(mv_src_o));
  a_r12_count_cleared: assert property (@(posedge clk) disable iff (rst)
    (mv_req_o && mv_done_i) |=> (qwc_o == '0));
  a_r9_no_empty_burst: assert property (@(posedge clk) disable iff (rst)
    mv_req_o |-> (mv_qwc_o != '0));
  a_r4_tag_excludes_burst: assert property (@(posedge clk) disable iff (rst)
    tag_req_o |-> !mv_req_o);
endmodule

bind chain_dma_seq chain_dma_seq_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .busy_o(busy_o), .done_irq_o(done_irq_o),
  .tag_req_o(tag_req_o), .mv_req_o(mv_req_o), .mv_done_i(mv_done_i),
  .mv_src_o(mv_src_o), .mv_qwc_o(mv_qwc_o), .qwc_o(qwc_o)
);

// File: tb/chain_dma_seq_tb_top.sv
`timescale 1ns/1ps
module chain_dma_seq_tb_top;
  localparam int AW = 32;
  localparam int CW = 16;
  localparam int TW = 64;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start_i = 1'b0, chain_i = 1'b0, irq_en_i = 1'b0, stall_sel_i = 1'b0;
  logic [CW-1:0] qwc_init_i = '0;
  logic [AW-1:0] madr_init_i = '0, sadr_init_i = '0;
  logic          tag_req_o, tag_vld_i = 1'b0;
  logic [AW-1:0] tag_addr_o;
  logic [TW-1:0] tag_data_i = '0;
  logic          mv_req_o, mv_done_i = 1'b0;
  logic [AW-1:0] mv_src_o, mv_dst_o;
  logic [CW-1:0] mv_qwc_o;
  logic          busy_o, done_irq_o, err_o;
  logic [AW-1:0] stall_addr_o, madr_o, sadr_o;
  logic [CW-1:0] qwc_o;

  always #4 clk = ~clk;

  chain_dma_seq #(.ADDR_W(AW), .CNT_W(CW), .TAG_W(TW)) dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .chain_i(chain_i), .irq_en_i(irq_en_i),
    .stall_sel_i(stall_sel_i), .qwc_init_i(qwc_init_i), .madr_init_i(madr_init_i),
    .sadr_init_i(sadr_init_i), .tag_req_o(tag_req_o), .tag_addr_o(tag_addr_o),
    .tag_vld_i(tag_vld_i), .tag_data_i(tag_data_i), .mv_req_o(mv_req_o),
    .mv_src_o(mv_src_o), .mv_dst_o(mv_dst_o), .mv_qwc_o(mv_qwc_o), .mv_done_i(mv_done_i),
    .busy_o(busy_o), .done_irq_o(done_irq_o), .err_o(err_o), .stall_addr_o(stall_addr_o),
    .qwc_o(qwc_o), .madr_o(madr_o), .sadr_o(sadr_o)
  );

  typedef struct packed { logic [AW-1:0] src; logic [AW-1:0] dst; logic [CW-1:0] qwc; } burst_t;
  burst_t exp_q[$];
  logic [TW-1:0] tagmem [logic [AW-1:0]];
  int checks = 0, fails = 0, fetches = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [TW-1:0] mk_tag(input logic [2:0] id, input bit irq,
                                           input logic [CW-1:0] cnt, input logic [AW-1:0] dst);
    logic [TW-1:0] t;
    t = '0;
    t[15:0] = cnt; t[30:28] = id; t[31] = irq; t[63:32] = dst;
    return t;
  endfunction

  task automatic push_exp(input logic [AW-1:0] s, input logic [AW-1:0] d, input logic [CW-1:0] q);
    burst_t b;
    b.src = s; b.dst = d; b.qwc = q;
    exp_q.push_back(b);
  endtask

  // tag port model
  initial forever begin
    @(negedge clk);
    tag_vld_i  = tag_req_o && !tag_vld_i;
    tag_data_i = tagmem.exists(tag_addr_o) ? tagmem[tag_addr_o] : '0;
  end

  // mover model: acknowledge two cycles after the request appears
  initial begin
    int mcnt = 0;
    forever begin
      @(negedge clk);
      if (mv_done_i) begin mv_done_i = 1'b0; mcnt = 0; end
      else if (mv_req_o) begin mcnt++; if (mcnt == 2) mv_done_i = 1'b1; end
    end
  end

  // monitor / scoreboard
  initial begin
    bit req_prev = 0, tag_prev = 0, ack_prev = 0;
    forever begin
      @(negedge clk);
      if (ack_prev) chk(qwc_o == '0, "R12", "count after burst", 64'(qwc_o), 64'h0);
      if (mv_req_o && !req_prev) begin
        if (exp_q.size() == 0) chk(1'b0, "R9", "unexpected burst", 64'(mv_src_o), 64'h0);
        else begin
          burst_t e;
          e = exp_q.pop_front();
          chk(mv_src_o == e.src, "R4", "burst source", 64'(mv_src_o), 64'(e.src));
          chk(mv_dst_o == e.dst, "R5", "burst destination", 64'(mv_dst_o), 64'(e.dst));
          chk(mv_qwc_o == e.qwc, "R5", "burst count", 64'(mv_qwc_o), 64'(e.qwc));
        end
      end
      if (tag_req_o && !tag_prev) fetches++;
      ack_prev = mv_req_o && mv_done_i;
      req_prev = mv_req_o;
      tag_prev = tag_req_o;
    end
  end

  task automatic run(input bit ch, input bit ie, input bit ss, input logic [CW-1:0] q,
                     input logic [AW-1:0] m, input logic [AW-1:0] s, input string req);
    bit seen = 0;
    @(negedge clk);
    fetches = 0;
    chain_i = ch; irq_en_i = ie; stall_sel_i = ss;
    qwc_init_i = q; madr_init_i = m; sadr_init_i = s; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int i = 0; i < 400 && !seen; i++) begin
      @(negedge clk);
      if (done_irq_o) seen = 1;
    end
    chk(seen, req, "completion irq", 64'(seen), 64'h1);
    chk(!busy_o, "R11", "busy at irq", 64'(busy_o), 64'h0);
    chk(exp_q.size() == 0, req, "bursts left", 64'(exp_q.size()), 64'h0);
    @(negedge clk);
    chk(!done_irq_o, "R11", "irq width", 64'(done_irq_o), 64'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(!busy_o && !done_irq_o && !err_o, "R1", "flags", {61'h0, busy_o, done_irq_o, err_o}, 64'h0);
    chk(!tag_req_o && !mv_req_o, "R1", "requests", {62'h0, tag_req_o, mv_req_o}, 64'h0);
    chk(stall_addr_o == '0 && qwc_o == '0, "R1", "stall/count", 64'(stall_addr_o), 64'h0);

    // R2 normal mode
    push_exp(32'h200, 32'h1000, 16'd4);
    run(1'b0, 1'b0, 1'b0, 16'd4, 32'h1000, 32'h200, "R2");
    chk(sadr_o == 32'h240, "R2", "source advance", 64'(sadr_o), 64'h240);
    chk(madr_o == 32'h1040, "R2", "dest advance", 64'(madr_o), 64'h1040);
    chk(fetches == 0, "R2", "tag reads", 64'(fetches), 64'h0);

    // R3 chain mode with preset count
    push_exp(32'h400, 32'h2000, 16'd3);
    run(1'b1, 1'b0, 1'b0, 16'd3, 32'h2000, 32'h400, "R3");
    chk(fetches == 0, "R3", "tag reads", 64'(fetches), 64'h0);

    // R4 R5 R6 R7 R9 full chain: CNT, CNTS(stall), CNT zero count, END
    tagmem[32'h00] = mk_tag(3'd1, 1'b0, 16'd2, 32'h5000);
    tagmem[32'h30] = mk_tag(3'd0, 1'b0, 16'd1, 32'h6000);
    tagmem[32'h50] = mk_tag(3'd1, 1'b0, 16'd0, 32'h6800);
    tagmem[32'h60] = mk_tag(3'd7, 1'b0, 16'd2, 32'h7000);
    push_exp(32'h10, 32'h5000, 16'd2);
    push_exp(32'h40, 32'h6000, 16'd1);
    push_exp(32'h70, 32'h7000, 16'd2);
    run(1'b1, 1'b0, 1'b1, 16'd0, 32'h0, 32'h0, "R6");
    chk(fetches == 4, "R9", "tag reads", 64'(fetches), 64'h4);
    chk(sadr_o == 32'h90, "R4", "final pointer", 64'(sadr_o), 64'h90);
    chk(stall_addr_o == 32'h6010, "R7", "stall address", 64'(stall_addr_o), 64'h6010);
    chk(!err_o, "R6", "no error", 64'(err_o), 64'h0);

    // R8 interrupt enable with tag IRQ ends chain
    tagmem[32'h100] = mk_tag(3'd1, 1'b1, 16'd1, 32'h8000);
    tagmem[32'h120] = mk_tag(3'd7, 1'b0, 16'd1, 32'h9000);
    push_exp(32'h110, 32'h8000, 16'd1);
    run(1'b1, 1'b1, 1'b0, 16'd0, 32'h0, 32'h100, "R8");
    chk(fetches == 1, "R8", "tag reads with irq_en", 64'(fetches), 64'h1);
    chk(sadr_o == 32'h120, "R8", "pointer", 64'(sadr_o), 64'h120);

    // R8 IRQ bit ignored when interrupt enable is off
    push_exp(32'h110, 32'h8000, 16'd1);
    push_exp(32'h130, 32'h9000, 16'd1);
    run(1'b1, 1'b0, 1'b0, 16'd0, 32'h0, 32'h100, "R8");
    chk(fetches == 2, "R8", "tag reads without irq_en", 64'(fetches), 64'h2);

    // R7 stall tag without stall select leaves stall register alone
    tagmem[32'h300] = mk_tag(3'd0, 1'b1, 16'd1, 32'hA000);
    push_exp(32'h310, 32'hA000, 16'd1);
    run(1'b1, 1'b1, 1'b0, 16'd0, 32'h0, 32'h300, "R7");
    chk(stall_addr_o == 32'h6010, "R7", "stall unchanged", 64'(stall_addr_o), 64'h6010);

    // R10 unsupported ID
    tagmem[32'h200] = mk_tag(3'd3, 1'b0, 16'd2, 32'hB000);
    run(1'b1, 1'b0, 1'b0, 16'd0, 32'h0, 32'h200, "R10");
    chk(err_o, "R10", "error flag", 64'(err_o), 64'h1);
    chk(qwc_o == '0, "R10", "count", 64'(qwc_o), 64'h0);
    chk(sadr_o == 32'h210, "R10", "pointer", 64'(sadr_o), 64'h210);

    // R10 error clears at next start
    push_exp(32'h500, 32'hC000, 16'd1);
    run(1'b0, 1'b0, 1'b0, 16'd1, 32'hC000, 32'h500, "R10");
    chk(!err_o, "R10", "error cleared", 64'(err_o), 64'h0);

    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule